// File: doc/BRIEF.md
# Serial DAC Input Control Logic

This block is the digital front end of a single-channel serial-input DAC. A frame on the serial port opens when the active-low select goes low. While select stays low, each rising edge of the serial clock shifts one data bit in, most significant bit first. When select goes high, the shift register contents are copied into an input register. The converter runs from a holding latch, and that latch is presented on `code_o`. The latch takes a new value in one of two ways. In deferred mode, a falling edge of the active-low load strobe copies the input register into the latch. In immediate mode the load strobe is held low, and the rising edge of select writes the shift register straight into the latch.

A falling edge of the active-low clear forces the latch to midscale: the MSB is 1 and every other bit is 0. For as long as clear stays low, the block ignores every load request, from either path. All control pins and the serial clock are asynchronous to `clk`. They pass through a synchronizer, and edges are found in the `clk` domain, so `clk` must oversample the serial clock. Resolution is set by `WIDTH`: 12 or 16 bits.

The shift side is a two-state frame machine: FRM_IDLE and FRM_SHIFT. FRM_IDLE moves to FRM_SHIFT on a select fall. FRM_SHIFT returns to FRM_IDLE on a select rise, and that transition produces the transfer pulse. The latch side is a two-state machine: LAT_RUN and LAT_CLEAR. LAT_RUN moves to LAT_CLEAR on a clear fall. LAT_CLEAR returns to LAT_RUN on a clear rise.

Top module: `dacfe_top`

## Requirements
- R1: While reset is asserted, and on leaving it, `code_o` equals midscale (bit WIDTH-1 set, all others 0) and `frame_err_o` is 0.
- R2: Bits present on `sdi_i` at rising `sclk_i` edges while `cs_n_i` is low enter the shift register MSB first. The rising edge of `cs_n_i` copies the register into the input register. With `load_n_i` high, `code_o` does not change.
- R3: A falling edge of `load_n_i` copies the input register into the latch, and `code_o` changes only on a transfer, a load or a clear.
- R4: With `load_n_i` held low, the rising edge of `cs_n_i` writes the newly shifted word into the latch.
- R5: If a frame carries more than WIDTH bits, only the last WIDTH bits are kept, and `frame_err_o` is set.
- R6: If a frame carries n < WIDTH bits, the word becomes the old word shifted left by n, with the n new bits in the low positions, and `frame_err_o` is set.
- R7: `frame_err_o` changes only at the end of a frame. A frame of exactly WIDTH bits clears it.
- R8: Serial clock edges while `cs_n_i` is high leave the shift register unchanged.
- R9: A falling edge of `clr_n_i` sets `code_o` to midscale.
- R10: While `clr_n_i` is low, load strobes and immediate-mode transfers leave `code_o` unchanged. The input register still captures frames.
- R11: An input change made between clock edges takes effect on `code_o` at the third rising edge of `clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial port |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock; data is taken on its rising edge |
| cs_n_i | input | 1 | Active-low frame select |
| sdi_i | input | 1 | Serial data, MSB first |
| load_n_i | input | 1 | Active-low latch load strobe |
| clr_n_i | input | 1 | Active-low clear to midscale, acting on its falling edge |
| code_o | output | WIDTH | Held DAC code word |
| frame_err_o | output | 1 | Last frame had a bit count different from WIDTH |

## Verification
Every pin passes through two synchronizer flops, and edge detection compares the second flop with a third. As a result, a latch or flag update lands on the third rising `clk` edge after the pin changes between edges. The bench drives pins on falling `clk` edges and samples on falling edges. Around a load it probes the output after the second and the third rising edge, to show that the old value holds and then the new one appears. Everywhere else it allows at least four cycles of settling before it compares against the bench model of the shift register, input register and latch.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    typedef enum logic {
        FRM_IDLE  = 1'b0,
        FRM_SHIFT = 1'b1
    } frm_state_t;

    typedef enum logic {
        LAT_RUN   = 1'b0,
        LAT_CLEAR = 1'b1
    } lat_state_t;

    localparam int CTL_SCLK = 0;
    localparam int CTL_CS   = 1;
    localparam int CTL_LOAD = 2;
    localparam int CTL_CLR  = 3;
    localparam int CTL_N    = 4;

    // idle levels: clear high, load high, select high, serial clock low
    localparam logic [CTL_N-1:0] CTL_IDLE = 4'b1110;
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int            N       = 1,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                pipe[s] <= RST_VAL;
            end
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) begin
                pipe[s] <= pipe[s-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/dacfe_shifter.sv
module dacfe_shifter
    import dacfe_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_low,
    input  logic             cs_fall,
    input  logic             cs_rise,
    input  logic             sclk_rise,
    input  logic             sdi,
    output logic [WIDTH-1:0] shreg,
    output logic             xfer,
    output logic             frame_err
);
    localparam int             CW       = $clog2(WIDTH + 2);
    localparam logic [CW-1:0]  CNT_FULL = CW'(WIDTH);
    localparam logic [CW-1:0]  CNT_SAT  = CW'(WIDTH + 1);

    frm_state_t    st, st_nx;
    logic [CW-1:0] cnt;
    logic          shift_en;

    assign shift_en = cs_low & sclk_rise;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FRM_IDLE;
        else        st <= st_nx;
    end

    // next state and transfer pulse
    always_comb begin
        st_nx = st;
        xfer  = 1'b0;
        unique case (st)
            FRM_IDLE: begin
                if (cs_fall) st_nx = FRM_SHIFT;
            end
            FRM_SHIFT: begin
                if (cs_rise) begin
                    st_nx = FRM_IDLE;
                    xfer  = 1'b1;
                end
            end
            default: st_nx = FRM_IDLE;
        endcase
    end

    // shift register keeps no reset: its content is undefined until written
    always_ff @(posedge clk) begin
        if (shift_en) shreg <= {shreg[WIDTH-2:0], sdi};
    end

    // bit counter and frame length flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            frame_err <= 1'b0;
        end else begin
            if (st == FRM_IDLE && cs_fall) begin
                cnt <= shift_en ? CW'(1) : '0;
            end else if (shift_en && cnt != CNT_SAT) begin
                cnt <= cnt + CW'(1);
            end
            if (xfer) frame_err <= (cnt != CNT_FULL);
        end
    end
endmodule

// File: rtl/dacfe_holdlatch.sv
module dacfe_holdlatch
    import dacfe_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer,
    input  logic             load_act,
    input  logic             load_fall,
    input  logic             clr_fall,
    input  logic             clr_rise,
    input  logic [WIDTH-1:0] shreg,
    output logic [WIDTH-1:0] code,
    output lat_state_t       lat_state
);
    localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

    lat_state_t       st_nx;
    logic [WIDTH-1:0] in_reg;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_state <= LAT_RUN;
        else        lat_state <= st_nx;
    end

    always_comb begin
        st_nx = lat_state;
        unique case (lat_state)
            LAT_RUN:   if (clr_fall) st_nx = LAT_CLEAR;
            LAT_CLEAR: if (clr_rise) st_nx = LAT_RUN;
            default:   st_nx = LAT_RUN;
        endcase
    end

    // input register and holding latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_reg <= MID;
            code   <= MID;
        end else begin
            if (xfer) in_reg <= shreg;
            unique case (lat_state)
                LAT_RUN: begin
                    if (clr_fall)               code <= MID;
                    else if (xfer && load_act)  code <= shreg;
                    else if (load_fall)         code <= in_reg;
                end
                LAT_CLEAR: begin
                    code <= code;
                end
                default: code <= MID;
            endcase
        end
    end
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
    import dacfe_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sclk_i,
    input  logic             cs_n_i,
    input  logic             sdi_i,
    input  logic             load_n_i,
    input  logic             clr_n_i,
    output logic [WIDTH-1:0] code_o,
    output logic             frame_err_o
);
    logic [CTL_N-1:0] ctl_raw, ctl_q, ctl_prev;
    logic             sdi_q;
    logic             sclk_rise, cs_rise, cs_fall, cs_high;
    logic             load_fall, load_act, clr_fall, clr_rise;
    logic             xfer;
    logic [WIDTH-1:0] shreg;
    lat_state_t       lat_state;

    assign ctl_raw[CTL_SCLK] = sclk_i;
    assign ctl_raw[CTL_CS]   = cs_n_i;
    assign ctl_raw[CTL_LOAD] = load_n_i;
    assign ctl_raw[CTL_CLR]  = clr_n_i;

    dacfe_sync #(.N(CTL_N), .STAGES(SYNC_STAGES), .RST_VAL(CTL_IDLE)) u_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_q)
    );

    dacfe_sync #(.N(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
        .clk(clk), .rst_n(rst_n), .d(sdi_i), .q(sdi_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_prev <= CTL_IDLE;
        else        ctl_prev <= ctl_q;
    end

    assign sclk_rise = ctl_q[CTL_SCLK] & ~ctl_prev[CTL_SCLK];
    assign cs_rise   = ctl_q[CTL_CS]   & ~ctl_prev[CTL_CS];
    assign cs_fall   = ~ctl_q[CTL_CS]  & ctl_prev[CTL_CS];
    assign cs_high   = ctl_q[CTL_CS];
    assign load_fall = ~ctl_q[CTL_LOAD] & ctl_prev[CTL_LOAD];
    assign load_act  = ~ctl_q[CTL_LOAD];
    assign clr_fall  = ~ctl_q[CTL_CLR] & ctl_prev[CTL_CLR];
    assign clr_rise  = ctl_q[CTL_CLR]  & ~ctl_prev[CTL_CLR];

    dacfe_shifter #(.WIDTH(WIDTH)) u_shifter (
        .clk(clk), .rst_n(rst_n),
        .cs_low(~cs_high), .cs_fall(cs_fall), .cs_rise(cs_rise),
        .sclk_rise(sclk_rise), .sdi(sdi_q),
        .shreg(shreg), .xfer(xfer), .frame_err(frame_err_o)
    );

    dacfe_holdlatch #(.WIDTH(WIDTH)) u_latch (
        .clk(clk), .rst_n(rst_n),
        .xfer(xfer), .load_act(load_act), .load_fall(load_fall),
        .clr_fall(clr_fall), .clr_rise(clr_rise), .shreg(shreg),
        .code(code_o), .lat_state(lat_state)
    );
endmodule

// File: rtl/dacfe_checker.sv
module dacfe_checker
    import dacfe_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] code_o,
    input logic             frame_err_o,
    input logic             xfer,
    input logic             load_fall,
    input logic             clr_fall,
    input logic             cs_high,
    input logic [WIDTH-1:0] shreg,
    input lat_state_t       lat_state
);
    localparam logic [WIDTH-1:0] MID = {1'b1, {(WIDTH-1){1'b0}}};

    AST_RESET_MIDSCALE: assert property (@(posedge clk)
        !rst_n |-> (code_o == MID && !frame_err_o)); // R1

    AST_NO_SPURIOUS_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer || load_fall || clr_fall) |=> $stable(code_o)); // R3

    AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        cs_high |=> $stable(shreg)); // R8

    AST_FLAG_AT_FRAME_END: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer |=> $stable(frame_err_o)); // R7

    AST_CLEAR_TO_MID: assert property (@(posedge clk) disable iff (!rst_n)
        clr_fall |=> code_o == MID); // R9

    AST_CLEAR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        lat_state == LAT_CLEAR |=> $stable(code_o)); // R10
endmodule

bind dacfe_top dacfe_checker #(.WIDTH(WIDTH)) u_dacfe_chk (
    .clk(clk), .rst_n(rst_n), .code_o(code_o), .frame_err_o(frame_err_o),
    .xfer(xfer), .load_fall(load_fall), .clr_fall(clr_fall),
    .cs_high(cs_high), .shreg(shreg), .lat_state(lat_state)
);

// File: tb/test_dacfe_top.sv
module test_dacfe_top;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int          W      = 16;
    localparam logic [W-1:0] MID   = {1'b1, {(W-1){1'b0}}};
    localparam int          WD_CYC = 150000;

    logic         clk = 1'b0;
    logic         rst_n, sclk, cs_n, sdi, load_n, clr_n;
    logic [W-1:0] code;
    logic         ferr;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    logic [W-1:0] m_sh, m_in, m_lat;
    logic         m_err;
    bit           m_clr;

    always #2.5 clk = ~clk;

    dacfe_top #(.WIDTH(W)) i_dacfe_top (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .cs_n_i(cs_n), .sdi_i(sdi),
        .load_n_i(load_n), .clr_n_i(clr_n), .code_o(code), .frame_err_o(ferr)
    );

    function automatic logic [W-1:0] shift_in(input logic [W-1:0] old,
                                              input int n, input logic [31:0] data);
        logic [W-1:0] r = old;
        for (int i = n - 1; i >= 0; i--) r = {r[W-2:0], data[i]};
        return r;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic frame(input int n, input logic [31:0] data);
        cs_n = 1'b0;
        tick(3);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = data[i];
            tick(2);
            sclk = 1'b1;
            tick(3);
            sclk = 1'b0;
            tick(1);
        end
        tick(2);
        cs_n = 1'b1;
        tick(5);
        m_sh  = shift_in(m_sh, n, data);
        m_in  = m_sh;
        m_err = (n != W);
        if (!load_n && !m_clr) m_lat = m_sh;
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        tick(4);
        load_n = 1'b1;
        tick(4);
        if (!m_clr) m_lat = m_in;
    endtask

    task automatic set_clr(input logic v);
        clr_n = v;
        tick(4);
        if (!v) begin
            m_clr = 1'b1;
            m_lat = MID;
        end else begin
            m_clr = 1'b0;
        end
    endtask

    initial begin
        #(WD_CYC * 5);
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        rst_n = 1'b1; sclk = 1'b0; cs_n = 1'b1; sdi = 1'b0; load_n = 1'b1; clr_n = 1'b1;
        m_sh = '0; m_in = MID; m_lat = MID; m_err = 1'b0; m_clr = 1'b0;
        #1 rst_n = 1'b0;
        tick(4);
        check("R1 reset code", code, MID);
        check("R1 reset flag", ferr, 0);
        rst_n = 1'b1;
        tick(3);
        check("R1 after reset", code, MID);

        // R2: deferred mode, latch untouched by the transfer
        frame(W, 32'hA5C3);
        check("R2 latch held", code, MID);
        check("R7 full frame flag", ferr, 0);
        pulse_load();
        check("R3 load copy", code, 16'hA5C3);

        // R11: load edge reaches the output on the third rising edge
        frame(W, 32'h1234);
        load_n = 1'b0;
        tick(2);
        check("R11 not before third edge", code, 16'hA5C3);
        tick(1);
        check("R11 at third edge", code, 16'h1234);
        load_n = 1'b1;
        tick(4);
        m_lat = m_in;

        // R4: immediate mode
        load_n = 1'b0;
        tick(4);
        frame(W, 32'hBEEF);
        check("R4 immediate update", code, 16'hBEEF);
        load_n = 1'b1;
        tick(4);

        // R5: overlong frame
        frame(W + 4, 32'hABCDE);
        check("R5 long flag", ferr, 1);
        pulse_load();
        check("R5 last bits kept", code, 16'hBCDE);

        // R6: short frame keeps older bits
        frame(4, 32'h9);
        check("R6 short flag", ferr, 1);
        pulse_load();
        check("R6 old bits shifted", code, 16'hCDE9);

        // R7: exact frame clears the flag
        frame(W, 32'h0F0F);
        check("R7 flag cleared", ferr, 0);

        // R8: serial clock with select high changes nothing
        for (int k = 0; k < 5; k++) begin
            sdi = k[0];
            tick(2); sclk = 1'b1; tick(3); sclk = 1'b0; tick(1);
        end
        frame(0, 32'h0);
        pulse_load();
        check("R8 idle clocks ignored", code, 16'h0F0F);
        check("R8 empty frame flag", ferr, 1);

        // R9 / R10: clear and blocking
        set_clr(1'b0);
        check("R9 clear to midscale", code, MID);
        pulse_load();
        check("R10 load ignored", code, MID);
        load_n = 1'b0;
        tick(4);
        frame(W, 32'h7777);
        check("R10 immediate ignored", code, MID);
        load_n = 1'b1;
        tick(4);
        set_clr(1'b1);
        check("R10 after release", code, MID);
        pulse_load();
        check("R10 input reg kept frame", code, 16'h7777);

        // constrained random mix
        seed = $urandom(32'h5EED_0D0C);
        for (int it = 0; it < 30; it++) begin
            int          n    = W - 2 + int'($urandom % 6);
            logic [31:0] data = $urandom;
            int          mode = int'($urandom % 3);
            if (mode == 1) begin
                load_n = 1'b0;
                tick(4);
                if (!m_clr) m_lat = m_in;
                frame(n, data);
                load_n = 1'b1;
                tick(4);
                check("R4 random immediate", code, m_lat);
            end else if (mode == 2) begin
                frame(n, data);
                set_clr(1'b0);
                pulse_load();
                set_clr(1'b1);
                check("R10 random clear", code, MID);
                pulse_load();
                check("R3 random after clear", code, m_lat);
            end else begin
                frame(n, data);
                pulse_load();
                check("R2 random deferred", code, m_lat);
            end
            check("R5 random flag", ferr, m_err);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule